// File: doc/BRIEF.md
# Timer Counter Clear-Source Selector

This block is a group of 16-bit up-counters, one per channel. Each channel owns a small set of general registers, and each register works either as an output-compare value or as an input-capture latch. A 3-bit clear-select field per channel decides which event, if any, returns that channel's counter to zero. The event can be a compare match or capture on one of the channel's own registers, or a clear that happens on a peer channel in the same synchronization group. All channels count on one shared count-enable input. Software reaches every control, counter and register value through a flat write/read port.

Channel 0 is the wide channel, with four general registers (A to D) and the full 3-bit select code. The other channels are narrow, with registers A and B only. On a narrow channel the top select bit is tied to zero, so only the lower four codes can be set. On the wide channel, registers C and D can each be flagged as buffers. A buffered register takes no part in compare, capture or clearing.

Top module: `clrsel_timer`

## Requirements
- R1: After reset every control word and the sync register read 0, every counter reads 0x0000, live general registers read 0xFFFF, and absent registers read 0x0000.
- R2: On each clock edge with `cnt_en` high and no clear or write, a counter adds one, wrapping from 0xFFFF to 0x0000. With `cnt_en` low it holds.
- R3: A register in compare mode raises its event bit `evt_o[4*ch+k]` (k = 0..3 for A..D) during a cycle where `cnt_en` is high and the counter equals the register. With `cnt_en` low there is no compare event.
- R4: Select code 1 clears on register A, 2 on B, 5 on C and 6 on D. On the edge where that register's event occurs the counter becomes 0 instead of incrementing. Codes 0 and 4 never clear.
- R5: A register in capture mode takes an event in the first cycle that its pin `cap_i[4*ch+k]` is high after being low. At that edge it latches the counter value from before the edge, and a capture-selected clear zeroes the counter at the same edge. A pin held high captures once.
- R6: Codes 3 and 7 clear the counter on the same edge as any register-sourced clear of a channel whose sync bit is set, but only when the channel's own sync bit is set. A register-sourced clear on a channel outside the group clears no peer.
- R7: When control bit 7 (C) or bit 8 (D) is set on the wide channel, that register produces no event, latches no capture, and its selected clear never happens.
- R8: On a narrow channel, control bits 2, 5, 6, 7 and 8 read 0 and ignore writes, so a written code c takes effect as c & 3. Registers C and D read 0.
- R9: A write to a counter takes priority over a clear or an increment on the same edge.
- R10: The address is {channel[1:0], offset[2:0]}. The offsets are 0 control, 1 counter, and 2 to 5 for registers A to D. Channel index 3, offset 0, is the sync register, whose bit n places channel n in the group. Control bits [2:0] hold the select code and bits [6:3] hold the capture-mode flags for A..D. Unmapped reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable shared by all channels |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address for write and read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| cap_i | input | 12 | Capture pins, four per channel |
| evt_o | output | 12 | Compare/capture event flags, four per channel |

## Verification
A counter write and a register-selected clear can land on the same edge. The bench sets up this case by holding `cnt_en` high while the counter equals register A under code 1, and it writes a new count across that same edge. The counter read back must show the written value and not zero. The second coincidence is a clear on a group member paired with a peer-code clear on another channel. The bench judges it by reading both counters after the edge and comparing them with a counter outside the group, which must have kept counting.

// File: rtl/clrsel_pkg.sv
package clrsel_pkg;

    localparam int NGR   = 4;
    localparam int OFS_W = 3;

    typedef enum logic [2:0] {
        OFS_CTRL = 3'd0,
        OFS_CNT  = 3'd1,
        OFS_GRA  = 3'd2,
        OFS_GRB  = 3'd3,
        OFS_GRC  = 3'd4,
        OFS_GRD  = 3'd5
    } ofs_e;

    typedef enum logic [2:0] {
        CLR_NONE    = 3'd0,
        CLR_GRA     = 3'd1,
        CLR_GRB     = 3'd2,
        CLR_PEER    = 3'd3,
        CLR_NONE_HI = 3'd4,
        CLR_GRC     = 3'd5,
        CLR_GRD     = 3'd6,
        CLR_PEER_HI = 3'd7
    } clr_sel_e;

    typedef struct packed {
        logic       buf_d;
        logic       buf_c;
        logic [3:0] cap_mode;
        clr_sel_e   clr_sel;
    } chan_ctrl_t;

    localparam int CTRL_W = $bits(chan_ctrl_t);

    function automatic logic sel_is_peer(clr_sel_e s);
        logic [2:0] v;
        v = s;
        return v[1:0] == 2'b11;
    endfunction

    function automatic logic sel_is_reg(clr_sel_e s);
        logic [2:0] v;
        v = s;
        return (v[1:0] == 2'b01) || (v[1:0] == 2'b10);
    endfunction

    function automatic logic [1:0] sel_reg_idx(clr_sel_e s);
        logic [2:0] v;
        v = s;
        return {v[2], v[1:0] == 2'b10};
    endfunction

    function automatic chan_ctrl_t narrow_mask(chan_ctrl_t c);
        chan_ctrl_t m;
        logic [2:0] v;
        m = c;
        v = c.clr_sel;
        m.buf_d         = 1'b0;
        m.buf_c         = 1'b0;
        m.cap_mode[3:2] = 2'b00;
        m.clr_sel       = clr_sel_e'({1'b0, v[1:0]});
        return m;
    endfunction

endpackage

// File: rtl/clrsel_edge.sv
module clrsel_edge #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= din;
    end

    assign rise = din & ~prev_q;
endmodule

// File: rtl/clrsel_group.sv
module clrsel_group #(
    parameter int NCH = 3
) (
    input  logic [NCH-1:0] src,
    input  logic [NCH-1:0] member,
    output logic           hit
);
    assign hit = |(src & member);
endmodule

// File: rtl/clrsel_chan.sv
module clrsel_chan
    import clrsel_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter bit WIDE  = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  chan_ctrl_t       ctrl,
    input  logic             sync_member,
    input  logic             peer_clr,
    input  logic             wr_cnt,
    input  logic [NGR-1:0]   wr_gr,
    input  logic [NGR-1:0]   cap_rise,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] gr_o [NGR],
    output logic [NGR-1:0]   evt_o,
    output logic             own_clr_o,
    output logic             clr_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [NGR-1:0]   live;
    logic [NGR-1:0]   hit_cmp;
    logic [NGR-1:0]   hit_cap;
    logic [1:0]       src_idx;

    // A buffered register on the wide channel drops out entirely.
    assign live = {~ctrl.buf_d & WIDE, ~ctrl.buf_c & WIDE, 2'b11};

    for (genvar k = 0; k < NGR; k++) begin : g_gr
        localparam bit KEEP = (k < 2) || WIDE;
        logic [CNT_W-1:0] gr_r;

        assign hit_cmp[k] = live[k] & ~ctrl.cap_mode[k] & cnt_en & (cnt_q == gr_r);
        assign hit_cap[k] = live[k] &  ctrl.cap_mode[k] & cap_rise[k];

        always_ff @(posedge clk) begin
            if (rst)                    gr_r <= KEEP ? '1 : '0;
            else if (KEEP && wr_gr[k])  gr_r <= wdata;
            else if (hit_cap[k])        gr_r <= cnt_q;
        end

        assign gr_o[k] = gr_r;
    end

    assign evt_o     = hit_cmp | hit_cap;
    assign src_idx   = sel_reg_idx(ctrl.clr_sel);
    assign own_clr_o = sel_is_reg(ctrl.clr_sel) & evt_o[src_idx];
    assign clr_o     = own_clr_o | (sync_member & sel_is_peer(ctrl.clr_sel) & peer_clr);

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (wr_cnt) cnt_q <= wdata;
        else if (clr_o)  cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/clrsel_timer.sv
module clrsel_timer
    import clrsel_pkg::*;
#(
    parameter int             NCH       = 3,
    parameter int             CNT_W     = 16,
    parameter logic [NCH-1:0] WIDE_MASK = NCH'(1),
    localparam int            CH_W      = $clog2(NCH + 1),
    localparam int            ADDR_W    = CH_W + OFS_W,
    localparam int            NEV       = NCH * NGR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    input  logic [NEV-1:0]    cap_i,
    output logic [NEV-1:0]    evt_o
);
    logic [CH_W-1:0]  a_ch;
    logic [OFS_W-1:0] a_ofs;
    chan_ctrl_t       ctrl_q [NCH];
    logic [NCH-1:0]   sync_q;
    logic [NEV-1:0]   cap_rise;
    logic [CNT_W-1:0] cnt_a [NCH];
    logic [CNT_W-1:0] gr_a  [NCH][NGR];
    logic [NCH-1:0]   own_clr_v;
    logic [NCH-1:0]   clr_v;
    logic [NCH-1:0]   wr_cnt_v;
    logic             grp_hit;
    chan_ctrl_t       wr_ctrl;

    assign a_ch    = addr[ADDR_W-1:OFS_W];
    assign a_ofs   = addr[OFS_W-1:0];
    assign wr_ctrl = chan_ctrl_t'(wdata[CTRL_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst)
            sync_q <= '0;
        else if (wr_en && a_ch == CH_W'(NCH) && a_ofs == OFS_CTRL)
            sync_q <= wdata[NCH-1:0];
    end

    clrsel_edge #(.W(NEV)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (cap_i),
        .rise (cap_rise)
    );

    clrsel_group #(.NCH(NCH)) u_group (
        .src    (own_clr_v),
        .member (sync_q),
        .hit    (grp_hit)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic           sel;
        logic [NGR-1:0] wr_gr;
        chan_ctrl_t     ctrl_r;

        assign sel         = wr_en && (a_ch == CH_W'(c));
        assign wr_cnt_v[c] = sel && (a_ofs == OFS_CNT);

        for (genvar k = 0; k < NGR; k++) begin : g_wr
            assign wr_gr[k] = sel && (a_ofs == OFS_W'(int'(OFS_GRA) + k));
        end

        always_ff @(posedge clk) begin
            if (rst)
                ctrl_r <= '0;
            else if (sel && a_ofs == OFS_CTRL)
                ctrl_r <= WIDE_MASK[c] ? wr_ctrl : narrow_mask(wr_ctrl);
        end

        assign ctrl_q[c] = ctrl_r;

        clrsel_chan #(
            .CNT_W (CNT_W),
            .WIDE  (WIDE_MASK[c])
        ) u_chan (
            .clk         (clk),
            .rst         (rst),
            .cnt_en      (cnt_en),
            .ctrl        (ctrl_r),
            .sync_member (sync_q[c]),
            .peer_clr    (grp_hit),
            .wr_cnt      (wr_cnt_v[c]),
            .wr_gr       (wr_gr),
            .cap_rise    (cap_rise[c*NGR +: NGR]),
            .wdata       (wdata),
            .cnt_o       (cnt_a[c]),
            .gr_o        (gr_a[c]),
            .evt_o       (evt_o[c*NGR +: NGR]),
            .own_clr_o   (own_clr_v[c]),
            .clr_o       (clr_v[c])
        );
    end

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (a_ch == CH_W'(c)) begin
                if (a_ofs == OFS_CTRL)
                    rdata = CNT_W'(ctrl_q[c]);
                else if (a_ofs == OFS_CNT)
                    rdata = cnt_a[c];
                else begin
                    for (int k = 0; k < NGR; k++) begin
                        if (a_ofs == OFS_W'(int'(OFS_GRA) + k))
                            rdata = gr_a[c][k];
                    end
                end
            end
        end
        if (a_ch == CH_W'(NCH) && a_ofs == OFS_CTRL)
            rdata = CNT_W'(sync_q);
    end
endmodule

// File: rtl/clrsel_chk.sv
module clrsel_chk
    import clrsel_pkg::*;
#(
    parameter int             NCH       = 3,
    parameter int             CNT_W     = 16,
    parameter logic [NCH-1:0] WIDE_MASK = NCH'(1)
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  cnt_en,
    input logic [CNT_W-1:0]      wdata,
    input logic [CNT_W-1:0]      cnt_a [NCH],
    input logic [NCH-1:0]        clr_v,
    input logic [NCH-1:0]        wr_cnt_v,
    input chan_ctrl_t            ctrl_q [NCH],
    input logic [NCH*NGR-1:0]    evt_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_c
        // R2
        count_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!cnt_en && !clr_v[c] && !wr_cnt_v[c]) |=> cnt_a[c] == $past(cnt_a[c]));
        // R2
        count_step_chk: assert property (@(posedge clk) disable iff (rst)
            (cnt_en && !clr_v[c] && !wr_cnt_v[c]) |=> cnt_a[c] == CNT_W'($past(cnt_a[c]) + 1'b1));
        // R4
        clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (clr_v[c] && !wr_cnt_v[c]) |=> cnt_a[c] == '0);
        // R9
        write_wins_chk: assert property (@(posedge clk) disable iff (rst)
            wr_cnt_v[c] |=> cnt_a[c] == $past(wdata));
        for (genvar k = 0; k < 2; k++) begin : g_k
            // R3
            compare_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
                (evt_o[c*NGR+k] && !ctrl_q[c].cap_mode[k]) |-> cnt_en);
        end
        if (WIDE_MASK[c]) begin : g_wide
            // R7
            buffer_c_quiet_chk: assert property (@(posedge clk) disable iff (rst)
                ctrl_q[c].buf_c |-> !evt_o[c*NGR+2]);
            // R7
            buffer_d_quiet_chk: assert property (@(posedge clk) disable iff (rst)
                ctrl_q[c].buf_d |-> !evt_o[c*NGR+3]);
        end else begin : g_narrow
            // R8
            narrow_quiet_chk: assert property (@(posedge clk) disable iff (rst)
                !evt_o[c*NGR+2] && !evt_o[c*NGR+3]);
        end
    end
endmodule

bind clrsel_timer clrsel_chk #(
    .NCH       (NCH),
    .CNT_W     (CNT_W),
    .WIDE_MASK (WIDE_MASK)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt_en   (cnt_en),
    .wdata    (wdata),
    .cnt_a    (cnt_a),
    .clr_v    (clr_v),
    .wr_cnt_v (wr_cnt_v),
    .ctrl_q   (ctrl_q),
    .evt_o    (evt_o)
);

// File: tb/clrsel_timer_bench.sv
module clrsel_timer_bench;
    localparam int NEV = 12;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cnt_en = 1'b0;
    logic            wr_en = 1'b0;
    logic [4:0]      addr = '0;
    logic [15:0]     wdata = '0;
    logic [15:0]     rdata;
    logic [NEV-1:0]  cap_i = '0;
    logic [NEV-1:0]  evt_o;

    int n_chk = 0;
    int n_bad = 0;
    int acc [NEV];
    bit done = 1'b0;

    clrsel_timer u_clrsel_timer (
        .clk    (clk),
        .rst    (rst),
        .cnt_en (cnt_en),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .cap_i  (cap_i),
        .evt_o  (evt_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic [4:0] ad(input int ch, input int ofs);
        return 5'(ch * 8 + ofs);
    endfunction

    task automatic wr(input int ch, input int ofs, input logic [15:0] d);
        wr_en = 1'b1; addr = ad(ch, ofs); wdata = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int ch, input int ofs, output logic [15:0] d);
        @(negedge clk);
        addr = ad(ch, ofs);
        #1 d = rdata;
    endtask

    task automatic run(input int n);
        for (int b = 0; b < NEV; b++) acc[b] = 0;
        cnt_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            #1;
            for (int b = 0; b < NEV; b++) if (evt_o[b]) acc[b]++;
            @(posedge clk); @(negedge clk);
        end
        cnt_en = 1'b0;
    endtask

    task automatic pulse(input int b, output logic e);
        cap_i[b] = 1'b1;
        #1 e = evt_o[b];
        @(posedge clk); @(negedge clk);
        cap_i[b] = 1'b0;
    endtask

    // Arithmetic expectation: n count edges from 0, all compare mode.
    function automatic void model(input int src, input int gv [4], input int nlive,
                                  input int n, input int watch, output int c, output int ev);
        c = 0; ev = 0;
        for (int i = 0; i < n; i++) begin
            if (watch < nlive && c == gv[watch]) ev++;
            if (src >= 0 && src < nlive && c == gv[src]) c = 0;
            else c = (c + 1) & 16'hFFFF;
        end
    endfunction

    task automatic sweep(input int ch, input int code, input int n, input int gv [4]);
        int eff, src, watch, ec, eev;
        logic [15:0] d;
        eff = (ch == 0) ? code : (code & 3);
        case (eff)
            1: src = 0;
            2: src = 1;
            5: src = 2;
            6: src = 3;
            default: src = -1;
        endcase
        watch = (src >= 0) ? src : 0;
        wr(ch, 0, 16'(code));
        wr(ch, 1, 16'h0000);
        run(n);
        model(src, gv, (ch == 0) ? 4 : 2, n, watch, ec, eev);
        rd(ch, 1, d);
        chk($sformatf("R4 ch%0d code%0d count", ch, code), 32'(d), 32'(ec));
        chk($sformatf("R3 ch%0d code%0d events", ch, code), 32'(acc[ch*4+watch]), 32'(eev));
        rd(ch, 0, d);
        chk($sformatf("R8 ch%0d code%0d select readback", ch, code), 32'(d), 32'(eff));
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic e;
        int g0 [4];
        int g1 [4];
        g0 = '{5, 7, 9, 11};
        g1 = '{4, 6, 0, 0};

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        for (int c = 0; c < 3; c++) begin
            rd(c, 0, d); chk("R1 ctrl", 32'(d), 0);
            rd(c, 1, d); chk("R1 count", 32'(d), 0);
            rd(c, 2, d); chk("R1 reg A", 32'(d), 32'hFFFF);
        end
        rd(0, 5, d); chk("R1 wide reg D", 32'(d), 32'hFFFF);
        rd(1, 4, d); chk("R1 narrow reg C absent", 32'(d), 0);
        rd(3, 0, d); chk("R1 sync reg", 32'(d), 0);

        // R10 unmapped addresses
        rd(0, 6, d); chk("R10 unmapped offset", 32'(d), 0);
        rd(3, 1, d); chk("R10 unmapped sync slot", 32'(d), 0);

        // R2 increment, wrap and hold
        wr(0, 1, 16'hFFFE);
        run(3);
        rd(0, 1, d); chk("R2 wrap", 32'(d), 1);
        repeat (4) @(negedge clk);
        rd(0, 1, d); chk("R2 hold", 32'(d), 1);

        // R4 / R3 / R8 sweep of all codes
        for (int k = 0; k < 4; k++) wr(0, 2 + k, 16'(g0[k]));
        for (int k = 0; k < 2; k++) wr(1, 2 + k, 16'(g1[k]));
        for (int code = 0; code < 8; code++) sweep(0, code, 20, g0);
        for (int code = 0; code < 8; code++) sweep(1, code, 20, g1);

        // R8 narrow upper bits and absent registers
        wr(1, 0, 16'h01F8);
        rd(1, 0, d); chk("R8 narrow upper ctrl bits", 32'(d), 32'h0018);
        wr(1, 4, 16'h1111);
        rd(1, 4, d); chk("R8 narrow reg C write ignored", 32'(d), 0);
        wr(1, 0, 16'h0000);

        // R3 compare needs count enable
        wr(0, 0, 16'h0000);
        wr(0, 2, 16'd8);
        wr(0, 1, 16'd8);
        @(negedge clk);
        #1 chk("R3 no event without enable", 32'(evt_o[0]), 0);
        cnt_en = 1'b1;
        #1 chk("R3 event with enable", 32'(evt_o[0]), 1);
        cnt_en = 1'b0;

        // R5 capture with clear on A
        wr(0, 0, 16'd9);
        wr(0, 1, 16'd0);
        run(7);
        pulse(0, e);
        chk("R5 capture event", 32'(e), 1);
        rd(0, 2, d); chk("R5 captured value", 32'(d), 7);
        rd(0, 1, d); chk("R5 capture clear", 32'(d), 0);

        // R5 held pin captures once
        wr(0, 0, 16'd8);
        wr(0, 1, 16'd20);
        cap_i[0] = 1'b1;
        run(3);
        cap_i[0] = 1'b0;
        chk("R5 single capture event", 32'(acc[0]), 1);
        rd(0, 2, d); chk("R5 held pin value", 32'(d), 20);
        rd(0, 1, d); chk("R5 no clear on code 0", 32'(d), 23);

        // R6 synchronous clear
        wr(0, 0, 16'd1);
        wr(0, 2, 16'd4);
        wr(1, 0, 16'd3);
        wr(2, 0, 16'd3);
        wr(3, 0, 16'b011);
        wr(0, 1, 16'd0);
        wr(1, 1, 16'd100);
        wr(2, 1, 16'd100);
        run(5);
        rd(0, 1, d); chk("R6 source cleared", 32'(d), 0);
        rd(1, 1, d); chk("R6 member cleared same edge", 32'(d), 0);
        rd(2, 1, d); chk("R6 non-member kept counting", 32'(d), 105);
        run(2);
        rd(1, 1, d); chk("R6 member after clear", 32'(d), 2);
        wr(3, 0, 16'b010);
        rd(3, 0, d); chk("R10 sync readback", 32'(d), 2);
        wr(0, 1, 16'd0);
        wr(1, 1, 16'd100);
        run(5);
        rd(1, 1, d); chk("R6 source outside group", 32'(d), 105);
        wr(3, 0, 16'd0);
        wr(1, 0, 16'd0);
        wr(2, 0, 16'd0);

        // R7 buffer suppression
        wr(0, 4, 16'd3);
        wr(0, 0, 16'd133);
        wr(0, 1, 16'd0);
        run(10);
        rd(0, 1, d); chk("R7 buffered C no clear", 32'(d), 10);
        chk("R7 buffered C no event", 32'(acc[2]), 0);
        wr(0, 0, 16'd5);
        wr(0, 1, 16'd0);
        run(10);
        rd(0, 1, d); chk("R7 unbuffered C clears", 32'(d), 2);
        chk("R7 unbuffered C events", 32'(acc[2]), 2);
        wr(0, 0, 16'd262);
        wr(0, 1, 16'd0);
        run(15);
        rd(0, 1, d); chk("R7 buffered D no clear", 32'(d), 15);
        chk("R7 buffered D no event", 32'(acc[3]), 0);
        wr(0, 0, 16'd160);
        wr(0, 1, 16'd50);
        pulse(2, e);
        chk("R7 buffered capture no event", 32'(e), 0);
        rd(0, 4, d); chk("R7 buffered capture no latch", 32'(d), 3);

        // R9 write wins over clear on the same edge
        wr(0, 0, 16'd1);
        wr(0, 2, 16'd3);
        wr(0, 1, 16'd3);
        @(negedge clk);
        cnt_en = 1'b1;
        #1 chk("R9 clear pending", 32'(evt_o[0]), 1);
        wr(0, 1, 16'h1234);
        cnt_en = 1'b0;
        rd(0, 1, d); chk("R9 write beats clear", 32'(d), 32'h1234);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule